// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Commit Sequencer

This block sits behind the serial front end of a page-organised non-volatile memory. A write command begins with a start address. Data bytes then arrive one at a time, and the command closes with a strobe raised when chip select goes high. The bytes are gathered into a one-page holding buffer. Each byte lands at the next offset inside the page named by the start address, and the offset wraps at the page boundary.

When the command closes, the buffer is committed to the array as one self-timed write cycle. During the commit the array sees only the bytes that were actually received, in ascending offset order, on a simple synchronous write port. A busy flag covers the whole cycle. The cycle length is a parameter in clock cycles and stands in for the bounded programming time of the silicon. While busy is high, new commands and changes to the write-enable latch are refused. The latch clears by itself when the cycle ends. An inhibit input, driven by protection logic outside the block, can cancel a command at the moment it closes.

The sequencer has four states:
- `SEQ_IDLE`: waits for a start. It goes to `SEQ_COLLECT` on a start while the latch is set.
- `SEQ_COLLECT`: stores bytes. On the end strobe it goes to `SEQ_COMMIT` if at least one byte was stored and inhibit is low. Otherwise it returns to `SEQ_IDLE`.
- `SEQ_COMMIT`: scans every page offset once. After the last offset it moves to `SEQ_SETTLE`.
- `SEQ_SETTLE`: waits for the cycle timer to expire, then returns to `SEQ_IDLE` and clears the latch.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, busy, wel and mem_we are all 0.
- R2: A wren_req pulse sets wel and a wrdi_req pulse clears it, each visible on the cycle after the pulse. A cmd_start while wel is 0 is refused: the bytes and end strobe that follow cause no array write and no busy period.
- R3: An accepted command takes its page from the upper address bits (cmd_addr divided by PAGE_BYTES) and its first offset from the lower bits. Each later byte goes to the next offset, and offset PAGE_BYTES-1 wraps to 0 within the same page.
- R4: Array writes occur only while busy. Every offset that received at least one byte is written exactly once, and no other offset is written. Writes within one cycle go in strictly ascending address order.
- R5: busy rises on the cycle after an accepted cmd_end and stays high for exactly TWR_CYCLES cycles.
- R6: While busy, cmd_start, byte_valid, wren_req and wrdi_req have no effect.
- R7: wel is 0 on the first cycle after busy falls.
- R8: If inhibit is high together with cmd_end, the collected bytes are discarded, no busy period starts, and wel stays set.
- R9: A command closed with no bytes received starts no busy period and leaves wel set.
- R10: When more than PAGE_BYTES bytes arrive, the last byte sent to an offset is the value committed there.
- R11: byte_valid outside an accepted command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wren_req | input | 1 | Pulse that sets the write-enable latch |
| wrdi_req | input | 1 | Pulse that clears the write-enable latch |
| cmd_start | input | 1 | Start of a write command, qualifies cmd_addr |
| cmd_addr | input | ADDR_W | Start address of the write |
| byte_valid | input | 1 | A data byte is present on byte_data |
| byte_data | input | 8 | Data byte |
| cmd_end | input | 1 | Command closed (chip select released) |
| inhibit | input | 1 | Protection veto, sampled with cmd_end |
| busy | output | 1 | Self-timed write cycle in progress |
| wel | output | 1 | Write-enable latch |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench sweeps every start offset of a 16-byte page against every length from 1 to 17 bytes, and computes the expected array contents arithmetically. A design that wrapped into the next page, or dropped the carry into the offset, would corrupt a neighbouring page. A design that committed the whole page would rewrite bytes that were never sent. A design that kept the first value of a repeated offset would fail the 17-byte cases. The busy window is counted cycle by cycle, so an off-by-one in the timer shows up directly. Commands attempted during busy, under inhibit, with the latch clear or with no bytes are each shown to leave the array and the latch untouched.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_COLLECT = 2'd1,
        SEQ_COMMIT  = 2'd2,
        SEQ_SETTLE  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pwb_page_store.sv
// One-page holding buffer: a data byte and a received flag per offset.
module pwb_page_store #(
    parameter  int unsigned PAGE_BYTES = 256,
    localparam int unsigned OFS_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [7:0]       wr_data,
    input  logic [OFS_W-1:0] rd_ofs,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             any_valid
);
    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_ofs] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vld_q <= '0;
        else if (clr)   vld_q <= '0;
        else if (wr_en) vld_q[wr_ofs] <= 1'b1;
    end

    always_comb begin
        rd_data   = data_q[rd_ofs];
        rd_valid  = vld_q[rd_ofs];
        any_valid = |vld_q;
    end

    // R3: a new command starts from an empty buffer
    p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_valid);
endmodule

// File: rtl/pwb_cycle_timer.sv
// Down-counter that measures the self-timed write cycle.
module pwb_cycle_timer #(
    parameter  int unsigned CYCLES = 2_000_000,
    localparam int unsigned CW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= CW'(CYCLES - 1);
        else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R5: a freshly loaded timer is never already expired
    p_load_not_expired_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);
endmodule

// File: rtl/pwb_wel_latch.sv
// Write-enable latch: host set/clear, frozen while busy, cleared when a cycle ends.
module pwb_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic freeze,
    input  logic done,
    output logic wel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wel <= 1'b0;
        else if (done)    wel <= 1'b0;
        else if (freeze)  wel <= wel;
        else if (clr_req) wel <= 1'b0;
        else if (set_req) wel <= 1'b1;
    end

    // R7: completion clears the latch
    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wel);
endmodule

// File: rtl/pwb_page_writer.sv
// Collects one page of write data and commits it as a self-timed cycle.
module pwb_page_writer
    import pwb_pkg::*;
#(
    parameter  int unsigned PAGE_BYTES = 256,
    parameter  int unsigned PAGES      = 1024,
    parameter  int unsigned TWR_CYCLES = 2_000_000,
    localparam int unsigned OFS_W      = $clog2(PAGE_BYTES),
    localparam int unsigned ADDR_W     = $clog2(PAGES * PAGE_BYTES),
    localparam int unsigned PG_W       = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_req,
    input  logic              wrdi_req,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cmd_end,
    input  logic              inhibit,
    output logic              busy,
    output logic              wel,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1);

    initial begin
        if (TWR_CYCLES <= PAGE_BYTES)
            $error("TWR_CYCLES must exceed PAGE_BYTES");
        if ((1 << OFS_W) != PAGE_BYTES)
            $error("PAGE_BYTES must be a power of two");
    end

    seq_state_t       state_q, state_d;
    logic [PG_W-1:0]  page_q;
    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] scan_q;

    logic accept, store_clr, store_wr, tmr_load, wel_done;
    logic rd_valid, any_valid, expired;
    logic [7:0] rd_data;

    assign accept = (state_q == SEQ_IDLE) && cmd_start && wel;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:    if (accept) state_d = SEQ_COLLECT;
            SEQ_COLLECT: if (cmd_end)
                             state_d = (inhibit || !any_valid) ? SEQ_IDLE : SEQ_COMMIT;
            SEQ_COMMIT:  if (scan_q == LAST_OFS) state_d = SEQ_SETTLE;
            SEQ_SETTLE:  if (expired) state_d = SEQ_IDLE;
            default:     state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // page, fill offset and commit scan registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ofs_q  <= '0;
            scan_q <= '0;
        end else begin
            if (accept) begin
                page_q <= cmd_addr[ADDR_W-1:OFS_W];
                ofs_q  <= cmd_addr[OFS_W-1:0];
            end else if (store_wr) begin
                ofs_q  <= ofs_q + 1'b1;
            end
            if (state_q == SEQ_COMMIT) scan_q <= scan_q + 1'b1;
            else                       scan_q <= '0;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == SEQ_COMMIT) || (state_q == SEQ_SETTLE);
        store_clr = accept;
        store_wr  = (state_q == SEQ_COLLECT) && byte_valid && !cmd_end;
        tmr_load  = (state_q == SEQ_COLLECT) && cmd_end && !inhibit && any_valid;
        wel_done  = (state_q == SEQ_SETTLE) && expired;
        mem_we    = (state_q == SEQ_COMMIT) && rd_valid;
        mem_addr  = {page_q, scan_q};
        mem_wdata = rd_data;
    end

    pwb_page_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (store_clr),
        .wr_en     (store_wr),
        .wr_ofs    (ofs_q),
        .wr_data   (byte_data),
        .rd_ofs    (scan_q),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pwb_cycle_timer #(.CYCLES(TWR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (busy),
        .expired (expired)
    );

    pwb_wel_latch u_wel (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wren_req),
        .clr_req (wrdi_req),
        .freeze  (busy),
        .done    (wel_done),
        .wel     (wel)
    );

    // R4: the array is written only inside a busy period
    p_we_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R5: a busy period begins only after a command end
    p_busy_from_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_end));

    // R6: the latch cannot change during a busy period
    p_wel_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wel));

    // R7: the latch is clear once the cycle is over
    p_fall_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R3: the target page does not move during a commit
    p_page_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_COMMIT && $past(state_q == SEQ_COMMIT)) |-> $stable(page_q));
endmodule

// File: tb/sim_pwb_page_writer.sv
module sim_pwb_page_writer;
    localparam int PB   = 16;
    localparam int NPG  = 8;
    localparam int TWR  = 40;
    localparam int MEMN = PB * NPG;
    localparam int AW   = $clog2(MEMN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wren_req = 0, wrdi_req = 0, cmd_start = 0, byte_valid = 0, cmd_end = 0, inhibit = 0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0] byte_data = '0;
    logic busy, wel, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;

    always #2.5 clk = ~clk;

    pwb_page_writer #(.PAGE_BYTES(PB), .PAGES(NPG), .TWR_CYCLES(TWR)) u0 (
        .clk(clk), .rst_n(rst_n), .wren_req(wren_req), .wrdi_req(wrdi_req),
        .cmd_start(cmd_start), .cmd_addr(cmd_addr), .byte_valid(byte_valid),
        .byte_data(byte_data), .cmd_end(cmd_end), .inhibit(inhibit),
        .busy(busy), .wel(wel), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [7:0] mem     [MEMN];
    logic [7:0] exp_mem [MEMN];
    int wr_cnt = 0;
    int order_err = 0;
    logic have_last = 1'b0;
    logic [AW-1:0] last_addr = '0;

    // array model and write monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < MEMN; a++) mem[a] = 8'h00;
        end else begin
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt++;
                if (have_last && mem_addr <= last_addr) order_err++;
                have_last = 1'b1;
                last_addr = mem_addr;
            end
            if (!busy) have_last = 1'b0;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_wren();
        wren_req = 1; tick(); wren_req = 0;
    endtask

    task automatic pulse_wrdi();
        wrdi_req = 1; tick(); wrdi_req = 0;
    endtask

    task automatic start_cmd(input int addr);
        cmd_start = 1; cmd_addr = AW'(addr); tick(); cmd_start = 0;
    endtask

    task automatic send(input logic [7:0] b);
        byte_valid = 1; byte_data = b; tick(); byte_valid = 0;
    endtask

    task automatic end_cmd(input logic inh);
        cmd_end = 1; inhibit = inh; tick(); cmd_end = 0; inhibit = 0;
    endtask

    function automatic int mem_mismatch();
        int bad = 0;
        for (int a = 0; a < MEMN; a++) if (mem[a] !== exp_mem[a]) bad++;
        return bad;
    endfunction

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; tick(); end
    endtask

    initial begin
        int n, w0, page, base, len;
        logic [7:0] d;
        for (int a = 0; a < MEMN; a++) exp_mem[a] = 8'h00;
        tick(); tick();
        rst_n = 1;
        tick();

        // R1
        check(busy == 0, "R1 busy", busy, 0);
        check(wel == 0, "R1 wel", wel, 0);
        check(mem_we == 0, "R1 mem_we", mem_we, 0);

        // R2: latch set and clear
        pulse_wren();
        check(wel == 1, "R2 set", wel, 1);
        pulse_wrdi();
        check(wel == 0, "R2 clear", wel, 0);

        // R2: start refused while latch clear
        w0 = wr_cnt;
        start_cmd(5); send(8'hAA); send(8'hBB); end_cmd(0);
        check(busy == 0, "R2 refused busy", busy, 0);
        tick();
        check(wr_cnt == w0, "R2 refused writes", wr_cnt - w0, 0);

        // R11: bytes with no command, then a one-byte command
        pulse_wren();
        send(8'h11); send(8'h22);
        w0 = wr_cnt;
        start_cmd(3 * PB + 7); send(8'h5C); end_cmd(0);
        exp_mem[3 * PB + 7] = 8'h5C;
        wait_idle(n);
        tick();
        check(wr_cnt - w0 == 1, "R11 single write", wr_cnt - w0, 1);
        check(mem_mismatch() == 0, "R11 contents", mem_mismatch(), 0);

        // R8: inhibit at end discards
        pulse_wren();
        w0 = wr_cnt;
        start_cmd(2 * PB); send(8'h01); send(8'h02); end_cmd(1);
        check(busy == 0, "R8 no busy", busy, 0);
        tick();
        check(wr_cnt == w0, "R8 no writes", wr_cnt - w0, 0);
        check(wel == 1, "R8 wel kept", wel, 1);

        // R9: no bytes
        start_cmd(4 * PB + 2); end_cmd(0);
        check(busy == 0, "R9 no busy", busy, 0);
        tick();
        check(wel == 1, "R9 wel kept", wel, 1);
        check(wr_cnt == w0, "R9 no writes", wr_cnt - w0, 0);

        // R6: traffic during busy is ignored
        w0 = wr_cnt;
        start_cmd(6 * PB + 14); send(8'hC1); send(8'hC2); end_cmd(0);
        exp_mem[6 * PB + 14] = 8'hC1;
        exp_mem[6 * PB + 15] = 8'hC2;
        tick();
        pulse_wren();
        start_cmd(1 * PB); send(8'hEE); send(8'hEF); end_cmd(0);
        pulse_wrdi(); pulse_wren();
        wait_idle(n);
        check(wel == 0, "R6 wel not set during busy", wel, 0);
        tick();
        check(wr_cnt - w0 == 2, "R6 write count", wr_cnt - w0, 2);
        check(mem_mismatch() == 0, "R6 contents", mem_mismatch(), 0);

        // R3 R4 R5 R7 R10: sweep offsets and lengths
        for (int off = 0; off < PB; off++) begin
            for (int ln = 1; ln <= PB + 1; ln++) begin
                page = (off * 17 + ln) % NPG;
                base = page * PB;
                len  = ln;
                pulse_wren();
                w0 = wr_cnt;
                start_cmd(base + off);
                for (int i = 0; i < len; i++) begin
                    d = 8'((off * 31 + ln * 7 + i * 13 + 1) & 255);
                    exp_mem[base + (off + i) % PB] = d;
                    send(d);
                end
                end_cmd(0);
                wait_idle(n);
                check(n == TWR, "R5 busy length", n, TWR);
                check(wel == 0, "R7 wel after cycle", wel, 0);
                check(wr_cnt - w0 == ((len > PB) ? PB : len), "R4 write count",
                      wr_cnt - w0, (len > PB) ? PB : len);
                check(mem_mismatch() == 0,
                      (len > PB) ? "R10 last byte wins" : "R3 contents",
                      mem_mismatch(), 0);
            end
        end
        check(order_err == 0, "R4 ascending order", order_err, 0);

        summary();
    end
endmodule